// File: doc/BRIEF.md
# I2C Controller Status Flag Unit

This block keeps the eight status flags of an I2C controller. It has no bus pins of its own. A separate protocol engine reports bus events to it as one-cycle strobes: a start seen on the bus, a stop seen on the bus, a start launched by this node, a lost arbitration, each rising SCL edge with its bit count, an address match, a direction load and an acknowledge sample. Software adds a release request, a read strobe and the interface enable. Every flag has its own set and clear events. All flags are registered on the system clock, and the 8-bit word is always visible on `status`.

The other logic reads `status` when it likes and asserts `rd_stb` for the cycle in which the read happens. The word shown during that cycle is the value before the read. The arbitration flag clears at the clock edge that ends the read cycle. When the enable falls, every flag clears. The block has no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `i2c_stat_flags`

## Requirements
- R1: While reset is asserted, and after it until the first event, `status` is 8'h00. The bit positions, MSB first, are: 7 master, 6 arbitration lost, 5 extension code, 4 address match, 3 transmit direction, 2 acknowledge, 1 start seen, 0 stop seen.
- R2: Bit 7 sets on `start_gen`. It clears on `stop_det`, `arb_lost` or `rel_req`.
- R3: `arb_lost` sets bit 6 and clears bit 7 at the same edge.
- R4: During an `rd_stb` cycle, `status` still shows the old bit 6. At the following edge bit 6 clears, unless `arb_lost` arrives in the same cycle, in which case it stays set.
- R5: Bit 5 sets when `scl_rise` is high, `scl_cnt` equals 8, `addr_phase` is high and `rx_addr[7:4]` is 4'b0000 or 4'b1111. It clears on `start_det`, `stop_det` or `rel_req`.
- R6: Bit 4 sets on `addr_match`. It clears on `start_det`, `stop_det` or `rel_req`.
- R7: On `dir_load`, bit 3 takes the value of `dir_tx`. It clears on `stop_det` or `rel_req`.
- R8: On `ack_stb`, bit 2 takes the value of `ack_in`. It clears on `start_det` or `stop_det`.
- R9: Bit 1 sets on `start_det` and clears on `stop_det`. Bit 0 sets on `stop_det` and clears on `start_det`. The two bits are never high together.
- R10: When `en` goes from 1 to 0, all bits are 0 after the next edge, whatever other events arrive in that cycle.
- R11: When a set event and a clear event reach the same flag in one cycle, the clear wins. The only exception is the arbitration flag described in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable level |
| start_det | input | 1 | Start condition seen on the bus |
| stop_det | input | 1 | Stop condition seen on the bus |
| start_gen | input | 1 | This node launched a start |
| arb_lost | input | 1 | Arbitration lost |
| scl_rise | input | 1 | Rising SCL edge |
| scl_cnt | input | 4 | Bit count of the current byte (1..8 at a rise) |
| addr_phase | input | 1 | The current byte is the address byte |
| rx_addr | input | 8 | Address bits received so far, first bit at MSB |
| addr_match | input | 1 | Own address matched |
| dir_load | input | 1 | Load the direction flag |
| dir_tx | input | 1 | Direction value: 1 = transmit |
| ack_stb | input | 1 | Acknowledge bit sampled |
| ack_in | input | 1 | Sampled acknowledge value: 1 = acknowledged |
| rel_req | input | 1 | Software asks to leave communication |
| rd_stb | input | 1 | The status word is read in this cycle |
| status | output | 8 | Status word |

## Verification
The bench targets these corner cases:
- A read that coincides with a new arbitration loss. A design that let the read win would drop a loss.
- A read that does not coincide with a loss. The word must show the old bit during the read cycle. A design that cleared early would return 0 to the reader.
- A start launched and a stop seen in the same cycle. A design that let set win would leave the node believing it is master.
- Extension-code candidates with the wrong clock count or a nibble other than 0000 or 1111. A loose comparator would flag these.
- An enable fall together with set strobes. A design that ordered these wrongly would leave flags standing after shutdown.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int STAT_W  = 8;
  localparam int B_MST   = 7;
  localparam int B_ARB   = 6;
  localparam int B_EXT   = 5;
  localparam int B_AMT   = 4;
  localparam int B_DIR   = 3;
  localparam int B_ACK   = 2;
  localparam int B_STA   = 1;
  localparam int B_STO   = 0;
  // flags whose set beats their soft clear
  localparam logic [STAT_W-1:0] SET_PRIO_MASK = 8'b0100_0000;
endpackage

// File: rtl/i2cs_flag_cell.sv
module i2cs_flag_cell #(
  parameter bit SET_PRIO = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= 1'b0;
    else if (kill)             q <= 1'b0;
    else if (SET_PRIO && set)  q <= 1'b1;
    else if (clr)              q <= 1'b0;
    else if (set)              q <= 1'b1;
  end
endmodule

// File: rtl/i2cs_ext_detect.sv
module i2cs_ext_detect #(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 4,
  parameter int EXT_CLK = 8,
  parameter int NIB_W   = 4
) (
  input  logic              scl_rise,
  input  logic [CNT_W-1:0]  scl_cnt,
  input  logic              addr_phase,
  input  logic [ADDR_W-1:0] rx_addr,
  output logic              hit
);
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(EXT_CLK);
  logic [NIB_W-1:0] top;
  assign top = rx_addr[ADDR_W-1 -: NIB_W];
  assign hit = scl_rise && addr_phase && (scl_cnt == CNT_HIT) &&
               ((top == '0) || (top == '1));
endmodule

// File: rtl/i2cs_fall_det.sv
module i2cs_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic fall
);
  logic d_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;
  end
  assign fall = d_q && !d;
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags #(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 4,
  parameter int EXT_CLK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              start_gen,
  input  logic              arb_lost,
  input  logic              scl_rise,
  input  logic [CNT_W-1:0]  scl_cnt,
  input  logic              addr_phase,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              addr_match,
  input  logic              dir_load,
  input  logic              dir_tx,
  input  logic              ack_stb,
  input  logic              ack_in,
  input  logic              rel_req,
  input  logic              rd_stb,
  output logic [7:0]        status
);
  import i2cs_pkg::*;

  logic en_fall, ext_hit;
  logic [STAT_W-1:0] set_v, clr_v, q_v;

  i2cs_fall_det u_fall (.clk(clk), .rst_n(rst_n), .d(en), .fall(en_fall));

  i2cs_ext_detect #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXT_CLK(EXT_CLK)) u_ext (
    .scl_rise(scl_rise), .scl_cnt(scl_cnt), .addr_phase(addr_phase),
    .rx_addr(rx_addr), .hit(ext_hit));

  always_comb begin
    set_v        = '0;
    clr_v        = '0;
    set_v[B_MST] = start_gen;
    clr_v[B_MST] = stop_det | arb_lost | rel_req;
    set_v[B_ARB] = arb_lost;
    clr_v[B_ARB] = rd_stb;
    set_v[B_EXT] = ext_hit;
    clr_v[B_EXT] = start_det | stop_det | rel_req;
    set_v[B_AMT] = addr_match;
    clr_v[B_AMT] = start_det | stop_det | rel_req;
    set_v[B_DIR] = dir_load & dir_tx;
    clr_v[B_DIR] = (dir_load & ~dir_tx) | stop_det | rel_req;
    set_v[B_ACK] = ack_stb & ack_in;
    clr_v[B_ACK] = (ack_stb & ~ack_in) | start_det | stop_det;
    set_v[B_STA] = start_det;
    clr_v[B_STA] = stop_det;
    set_v[B_STO] = stop_det;
    clr_v[B_STO] = start_det;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    i2cs_flag_cell #(.SET_PRIO(SET_PRIO_MASK[i])) u_cell (
      .clk(clk), .rst_n(rst_n), .kill(en_fall),
      .set(set_v[i]), .clr(clr_v[i]), .q(q_v[i]));
  end

  assign status = q_v;

  // R3
  arb_drops_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !status[B_MST]);
  // R4
  arb_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !en_fall) |=> status[B_ARB]);
  // R4
  rd_clears_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !arb_lost) |=> !status[B_ARB]);
  // R10
  en_fall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> (status == 8'h00));
  // R9
  sta_sto_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[B_STA] && status[B_STO]));
  // R5
  ext_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[B_EXT]) |-> $past(ext_hit));
endmodule

// File: tb/sim_i2c_stat_flags.sv
module sim_i2c_stat_flags;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic start_det = 0, stop_det = 0, start_gen = 0, arb_lost = 0, scl_rise = 0;
  logic [3:0] scl_cnt = '0;
  logic addr_phase = 0;
  logic [7:0] rx_addr = '0;
  logic addr_match = 0, dir_load = 0, dir_tx = 0, ack_stb = 0, ack_in = 0;
  logic rel_req = 0, rd_stb = 0;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_s = 8'h00;
  logic en_pm = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_stat_flags u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .start_det(start_det), .stop_det(stop_det),
    .start_gen(start_gen), .arb_lost(arb_lost), .scl_rise(scl_rise), .scl_cnt(scl_cnt),
    .addr_phase(addr_phase), .rx_addr(rx_addr), .addr_match(addr_match),
    .dir_load(dir_load), .dir_tx(dir_tx), .ack_stb(ack_stb), .ack_in(ack_in),
    .rel_req(rel_req), .rd_stb(rd_stb), .status(status));

  function automatic logic [7:0] model_next(input logic [7:0] s);
    logic [7:0] n;
    if (en_pm && !en) return 8'h00;                       // R10
    n = s;
    if (start_gen) n[7] = 1;                               // R2
    if (stop_det || arb_lost || rel_req) n[7] = 0;         // R2 R3 R11
    if (rd_stb) n[6] = 0;                                  // R4
    if (arb_lost) n[6] = 1;                                // R3
    if (scl_rise && scl_cnt == 4'd8 && addr_phase &&
        (rx_addr[7:4] == 4'h0 || rx_addr[7:4] == 4'hF)) n[5] = 1;  // R5
    if (start_det || stop_det || rel_req) n[5] = 0;
    if (addr_match) n[4] = 1;                              // R6
    if (start_det || stop_det || rel_req) n[4] = 0;
    if (dir_load) n[3] = dir_tx;                           // R7
    if (stop_det || rel_req) n[3] = 0;
    if (ack_stb) n[2] = ack_in;                            // R8
    if (start_det || stop_det) n[2] = 0;
    if (start_det) n[1] = 1;                               // R9
    if (stop_det) n[1] = 0;
    if (stop_det) n[0] = 1;
    if (start_det) n[0] = 0;
    return n;
  endfunction

  function automatic string req_of(input logic [7:0] d);
    if (d[7]) return "R2";
    if (d[6]) return "R4";
    if (d[5]) return "R5";
    if (d[4]) return "R6";
    if (d[3]) return "R7";
    if (d[2]) return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [7:0] e);
    checks++;
    if (status !== e) begin
      errors++;
      $display("FAIL %s/%s: status=%02h expected=%02h", tag, req_of(status ^ e), status, e);
    end
  endtask

  task automatic idle();
    start_det = 0; stop_det = 0; start_gen = 0; arb_lost = 0; scl_rise = 0;
    addr_phase = 0; addr_match = 0; dir_load = 0; ack_stb = 0;
    rel_req = 0; rd_stb = 0;
  endtask

  // inputs already set at a negedge; advance one edge and compare
  task automatic cycle(input string tag);
    exp_s = model_next(exp_s);
    en_pm = en;
    @(negedge clk);
    check(tag, exp_s);
    idle();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: status=%02h expected=done", status);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", 8'h00);
    en = 1'b1; cycle("R1");

    start_gen = 1; cycle("R2 set");
    rel_req = 1; cycle("R2 release");
    start_gen = 1; cycle("R2 set");
    arb_lost = 1; cycle("R3");
    rd_stb = 1; check("R4 old value", exp_s); cycle("R4 read");
    arb_lost = 1; cycle("R4 set");
    rd_stb = 1; arb_lost = 1; cycle("R4 read+loss");
    rd_stb = 1; cycle("R4 read");

    scl_rise = 1; addr_phase = 1; scl_cnt = 8; rx_addr = 8'hF3; cycle("R5 ones");
    start_det = 1; cycle("R5 clear");
    scl_rise = 1; addr_phase = 1; scl_cnt = 8; rx_addr = 8'h53; cycle("R5 other");
    scl_rise = 1; addr_phase = 1; scl_cnt = 7; rx_addr = 8'h0A; cycle("R5 cnt7");
    scl_rise = 1; addr_phase = 1; scl_cnt = 8; rx_addr = 8'h0A; cycle("R5 zeros");

    start_gen = 1; stop_det = 1; cycle("R11");
    addr_match = 1; start_det = 1; cycle("R11 amt");
    start_det = 1; stop_det = 1; cycle("R9 both");

    addr_match = 1; dir_load = 1; dir_tx = 1; ack_stb = 1; ack_in = 1; cycle("R6 R7 R8");
    en = 0; start_gen = 1; arb_lost = 1; addr_match = 1; cycle("R10");
    en = 1; cycle("R10 re-enable");

    for (int i = 0; i < 4000; i++) begin
      start_det  = ($urandom % 10) == 0;
      stop_det   = ($urandom % 10) == 0;
      start_gen  = ($urandom % 6) == 0;
      arb_lost   = ($urandom % 12) == 0;
      scl_rise   = ($urandom % 3) == 0;
      scl_cnt    = ($urandom % 3 == 0) ? 4'd8 : 4'($urandom % 10);
      addr_phase = ($urandom % 2) == 0;
      case ($urandom % 3)
        0: rx_addr = {4'h0, 4'($urandom)};
        1: rx_addr = {4'hF, 4'($urandom)};
        default: rx_addr = 8'($urandom);
      endcase
      addr_match = ($urandom % 8) == 0;
      dir_load   = ($urandom % 8) == 0;
      dir_tx     = 1'($urandom);
      ack_stb    = ($urandom % 5) == 0;
      ack_in     = 1'($urandom);
      rel_req    = ($urandom % 14) == 0;
      rd_stb     = ($urandom % 5) == 0;
      en         = (($urandom % 64) == 0) ? 1'b0 : 1'b1;
      if (rd_stb) check("R4 read value", exp_s);
      cycle("rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule